// File: doc/BRIEF.md
# Call-Injecting Prioritized Interrupt Controller

This block sits on the bus of an 8-bit processor that, when it takes an interrupt, expects the interrupting hardware to supply an instruction. Eight request lines are ranked by fixed priority. Each line has its own programmable 16-bit service address. The block drives the processor's single active-low interrupt request.

There is no acknowledge pin. The block treats an opcode-fetch strobe together with an I/O-request strobe as the acknowledge. During that cycle it places a subroutine-call opcode on the data bus. The processor then fetches the two address bytes with ordinary memory reads. An injection flip-flop, set by the acknowledge and cleared by the next opcode fetch, lets the block answer those two reads. It also raises a memory-inhibit output so that normal memory stays off the bus.

The controller then counts as busy. It watches opcode fetches and rearms only after it sees the return-from-interrupt opcode pair fetched back to back. Software programs the block through plain I/O write cycles at a base address.

Top module: `vec_call_intc`

## Requirements
- R1: After reset, `int_n` is high, `data_oe` and `mem_inhibit` are low, every input is masked, and every service address is 0x0000.
- R2: An I/O write (`iorq_n`=0, `wr_n`=0, `m1_n`=1) to offset k of `IO_BASE` (default 0x40) sets register k. Offsets 0..7 hold the low address byte of inputs 0..7, offsets 8..15 hold the high byte, and offset 16 is the mask register, where bit i set to 1 masks input i.
- R3: `int_n` is low exactly when some unmasked input is high and no service is in progress. A masked input never pulls `int_n` low.
- R4: During an acknowledge (`m1_n`=0, `iorq_n`=0) taken with an unmasked request pending, the block drives 0xCD on `data_out` with `data_oe` high. `int_n` goes high on the next clock.
- R5: While injecting, the first memory read (`m1_n`=1, `mreq_n`=0, `rd_n`=0) after the acknowledge returns the low address byte and the second returns the high byte. `mem_inhibit` is high during both reads.
- R6: When several unmasked inputs are pending, input 0 has the highest priority and input 7 the lowest.
- R7: The serviced input is latched at the acknowledge. Requests that change afterwards do not alter the address bytes supplied.
- R8: After the three bytes have been supplied, further memory reads get neither `data_oe` nor `mem_inhibit`. An opcode fetch ends the injection.
- R9: Once an acknowledge is taken, the block stays busy (`int_n` high) until an opcode fetch of 0xED is followed directly by an opcode fetch of 0x4D. A 0xED followed by any other opcode does not rearm.
- R10: I/O writes to offsets outside 0..16 of the base, or to other addresses, leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 8 | Interrupt requests, level-sensitive, bit 0 highest priority |
| m1_n | input | 1 | Opcode-fetch strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| io_addr | input | 8 | Low address byte, used for I/O decode |
| data_in | input | 8 | Data bus as seen by the block (writes and opcode snooping) |
| data_out | output | 8 | Byte driven toward the processor |
| data_oe | output | 1 | High while `data_out` should drive the bus |
| mem_inhibit | output | 1 | High while normal memory must not answer a read |
| int_n | output | 1 | Interrupt request to the processor, active low |

## Verification
Faults in the internal state show up at the bus outputs within one bus cycle.

- A wrongly latched or updated source index appears as a wrong address byte on the first or second injected read.
- A faulty byte counter shows up in three ways: a missing or repeated opcode, a third read that is still driven, or `mem_inhibit` that is still raised.
- A busy flag that clears on the wrong opcode sequence shows up as `int_n` falling before the return pair completes. A busy flag that never clears shows up as `int_n` staying high after it.

The directed scenarios place each of these sequences, and the broken 0xED-then-other pattern, directly in front of an `int_n` or data-bus sample.

// File: rtl/vec_call_intc.sv
module vec_call_intc #(
  parameter int         N_SRC     = 8,
  parameter logic [7:0] IO_BASE   = 8'h40,
  parameter logic [7:0] CALL_OP   = 8'hCD,
  parameter logic [7:0] RETI_PRE  = 8'hED,
  parameter logic [7:0] RETI_OP   = 8'h4D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_in,
  input  logic             m1_n,
  input  logic             iorq_n,
  input  logic             mreq_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [7:0]       io_addr,
  input  logic [7:0]       data_in,
  output logic [7:0]       data_out,
  output logic             data_oe,
  output logic             mem_inhibit,
  output logic             int_n
);
  localparam int SW       = $clog2(N_SRC);
  localparam int MASK_OFS = 2 * N_SRC;

  logic [7:0]       vec_lo [N_SRC];
  logic [7:0]       vec_hi [N_SRC];
  logic [N_SRC-1:0] mask;
  logic [SW-1:0]    src, win;
  logic [1:0]       idx;
  logic [7:0]       op_lat;
  logic             busy, inj, saw_pre;
  logic             ack_q, memrd_q, fetch_q, iowr_q;

  wire ack   = ~m1_n & ~iorq_n;
  wire fetch = ~m1_n & ~mreq_n & ~rd_n;
  wire memrd = m1_n & ~mreq_n & ~rd_n;
  wire iowr  = m1_n & ~iorq_n & ~wr_n;
  wire [7:0] ofs = io_addr - IO_BASE;
  wire [N_SRC-1:0] pend = req_in & ~mask;
  wire feeding = inj & (idx != 2'd3);

  always_comb begin
    win = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pend[i]) win = SW'(i);
  end

  always_comb begin
    case (idx)
      2'd0:    data_out = CALL_OP;
      2'd1:    data_out = vec_lo[src];
      2'd2:    data_out = vec_hi[src];
      default: data_out = 8'h00;
    endcase
  end

  assign data_oe     = feeding & (ack | memrd);
  assign mem_inhibit = feeding & memrd;
  assign int_n       = ~((|pend) & ~busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SRC; i++) begin
        vec_lo[i] <= 8'h00;
        vec_hi[i] <= 8'h00;
      end
      mask    <= '1;
      src     <= '0;
      idx     <= 2'd0;
      op_lat  <= 8'h00;
      busy    <= 1'b0;
      inj     <= 1'b0;
      saw_pre <= 1'b0;
      ack_q   <= 1'b0;
      memrd_q <= 1'b0;
      fetch_q <= 1'b0;
      iowr_q  <= 1'b0;
    end else begin
      ack_q   <= ack;
      memrd_q <= memrd;
      fetch_q <= fetch;
      iowr_q  <= iowr;

      if (iowr && !iowr_q) begin
        if (int'(ofs) < N_SRC)          vec_lo[ofs[SW-1:0]] <= data_in;
        else if (int'(ofs) < MASK_OFS)  vec_hi[ofs[SW-1:0]] <= data_in;
        else if (int'(ofs) == MASK_OFS) mask <= data_in[N_SRC-1:0];
      end

      if (ack && !ack_q && !busy && (|pend)) begin
        busy <= 1'b1;
        inj  <= 1'b1;
        src  <= win;
        idx  <= 2'd0;
      end
      if (!ack && ack_q && feeding)     idx <= idx + 2'd1;
      if (!memrd && memrd_q && feeding) idx <= idx + 2'd1;

      if (fetch && !fetch_q) inj <= 1'b0;
      if (fetch) op_lat <= data_in;
      if (!fetch && fetch_q) begin
        saw_pre <= (op_lat == RETI_PRE);
        if (saw_pre && op_lat == RETI_OP) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vec_call_intc_chk.sv
module vec_call_intc_chk #(
  parameter int N_SRC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             m1_n,
  input logic             iorq_n,
  input logic             mreq_n,
  input logic             rd_n,
  input logic             int_n,
  input logic             data_oe,
  input logic             mem_inhibit,
  input logic             busy,
  input logic [$clog2(N_SRC)-1:0] src
);
  p_ack_drops_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!m1_n && !iorq_n && !int_n) |=> int_n);

  p_oe_needs_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> busy);

  p_inhibit_on_memrd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_inhibit |-> (m1_n && !mreq_n && !rd_n));

  p_oe_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> ((!rd_n && !mreq_n) || (!m1_n && !iorq_n)));

  p_src_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(src));

  p_busy_masks_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> int_n);
endmodule

bind vec_call_intc vec_call_intc_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .iorq_n(iorq_n), .mreq_n(mreq_n),
  .rd_n(rd_n), .int_n(int_n), .data_oe(data_oe), .mem_inhibit(mem_inhibit),
  .busy(busy), .src(src)
);

// File: tb/tb_vec_call_intc.sv
module tb_vec_call_intc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = 8'h00;
  logic       m1_n = 1'b1, iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] io_addr = 8'h00, data_in = 8'h00;
  logic [7:0] data_out;
  logic       data_oe, mem_inhibit, int_n;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  vec_call_intc dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .m1_n(m1_n), .iorq_n(iorq_n),
    .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .io_addr(io_addr),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .mem_inhibit(mem_inhibit), .int_n(int_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; data_in = d; iorq_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_ack(output logic [7:0] d, output logic oe, output logic irq_n);
    @(negedge clk);
    m1_n = 1'b0; iorq_n = 1'b0;
    repeat (2) @(negedge clk);
    d = data_out; oe = data_oe; irq_n = int_n;
    m1_n = 1'b1; iorq_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic mem_read(output logic [7:0] d, output logic oe, output logic inh);
    @(negedge clk);
    mreq_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    d = data_out; oe = data_oe; inh = mem_inhibit;
    @(negedge clk);
    mreq_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic op_fetch(input logic [7:0] op, output logic oe, output logic inh);
    @(negedge clk);
    m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0; data_in = op;
    @(negedge clk);
    oe = data_oe; inh = mem_inhibit;
    @(negedge clk);
    m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(int_n === 1'b1, "R1 int_n", int_n, 1);
    check(data_oe === 1'b0 && mem_inhibit === 1'b0, "R1 outputs", {data_oe, mem_inhibit}, 0);
    req_in = 8'hFF;
    @(negedge clk);
    check(int_n === 1'b1, "R1 all masked", int_n, 1);
    req_in = 8'h00;
  endtask

  task automatic t_program;
    io_write(8'h40, 8'h11); io_write(8'h48, 8'hA0);
    io_write(8'h42, 8'h22); io_write(8'h4A, 8'hB2);
    io_write(8'h45, 8'h55); io_write(8'h4D, 8'hC5);
    io_write(8'h50, 8'h80);
    @(negedge clk);
    check(int_n === 1'b1, "R3 idle", int_n, 1);
    req_in = 8'h80;
    @(negedge clk);
    check(int_n === 1'b1, "R3 masked input 7", int_n, 1);
    req_in = 8'h20;
    @(negedge clk);
    check(int_n === 1'b0, "R3 unmasked input 5", int_n, 0);
  endtask

  task automatic t_service_priority;
    logic [7:0] d; logic oe, x;
    req_in = 8'h24;
    do_ack(d, oe, x);
    check(oe === 1'b1 && d === 8'hCD, "R4 call opcode", d, 8'hCD);
    check(x === 1'b1, "R4 int_n released", x, 1);
    req_in = 8'h25;
    mem_read(d, oe, x);
    check(oe && x && d === 8'h22, "R5 R6 low byte input 2", d, 8'h22);
    mem_read(d, oe, x);
    check(oe && x && d === 8'hB2, "R5 R7 high byte input 2", d, 8'hB2);
    mem_read(d, oe, x);
    check(oe === 1'b0 && x === 1'b0, "R8 third read undriven", {oe, x}, 0);
    op_fetch(8'h00, oe, x);
    check(oe === 1'b0 && x === 1'b0, "R8 fetch undriven", {oe, x}, 0);
    mem_read(d, oe, x);
    check(oe === 1'b0 && x === 1'b0, "R8 after fetch", {oe, x}, 0);
  endtask

  task automatic t_return;
    logic oe, x;
    check(int_n === 1'b1, "R9 busy holds off", int_n, 1);
    op_fetch(8'hED, oe, x);
    op_fetch(8'h00, oe, x);
    check(int_n === 1'b1, "R9 broken pair", int_n, 1);
    op_fetch(8'h4D, oe, x);
    check(int_n === 1'b1, "R9 4D alone", int_n, 1);
    op_fetch(8'hED, oe, x);
    op_fetch(8'h4D, oe, x);
    check(int_n === 1'b0, "R9 rearmed", int_n, 0);
  endtask

  task automatic t_ignored_writes;
    logic [7:0] d; logic oe, x;
    io_write(8'h51, 8'h00); io_write(8'h3F, 8'h00); io_write(8'h60, 8'hEE);
    req_in = 8'h20;
    do_ack(d, oe, x);
    check(d === 8'hCD, "R4 second ack opcode", d, 8'hCD);
    mem_read(d, oe, x);
    check(oe && d === 8'h55, "R10 R2 low byte kept", d, 8'h55);
    mem_read(d, oe, x);
    check(oe && d === 8'hC5, "R10 R2 high byte kept", d, 8'hC5);
    op_fetch(8'h00, oe, x);
    op_fetch(8'hED, oe, x);
    op_fetch(8'h4D, oe, x);
    req_in = 8'h80;
    @(negedge clk);
    check(int_n === 1'b1, "R10 mask kept", int_n, 1);
    req_in = 8'h01;
    @(negedge clk);
    check(int_n === 1'b0, "R6 input 0 unmasked", int_n, 0);
    do_ack(d, oe, x);
    mem_read(d, oe, x);
    check(d === 8'h11, "R6 input 0 low byte", d, 8'h11);
    mem_read(d, oe, x);
    check(d === 8'hA0, "R6 input 0 high byte", d, 8'hA0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_program;
    t_service_priority;
    t_return;
    t_ignored_writes;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule